// File: doc/BRIEF.md
# Two-Strike Processor Watchdog

This block supervises a processor through a single kick line. Each change on the kick line, whether rising or falling, restarts a timeout counter. If the counter runs out before the next change, the block drives a short active-low fault pulse. One clock later it pulls an active-low fault level down. The fault level then stays low until the kick line changes again.

A shutdown flag is updated on each fault pulse by copying the current fault level into it. On a first missed kick the level is still high at that moment, so the flag does not change. When a second timeout expires and no kick has come in between, the level is already low and the flag drops. This raises a persistent reset request. After that, only the reactivate input can clear the latch; kicks have no effect on it.

The timeout length, in clock cycles, is chosen by a select input from two parameters. The pulse length is also a parameter. The defaults assume a 200 MHz clock: 1.6 s normal timeout, about 21 ms alternative timeout and a 1 ms pulse.

Top module: `wdog_two_strike`

## Requirements
- R1: While rst_n is low, and directly after reset, fault_n = 1, fault_pulse_n = 1, shutdown_n = 1 and reset_req = 0.
- R2: The kick input passes through a two-flop synchronizer. A rising or falling change on kick restarts the count. With no further change, fault_pulse_n goes low at the (N+3)th rising clock edge after the change, where N is the selected timeout.
- R3: The timeout N is ALT_TIMEOUT_CYC when alt_sel = 1 and TIMEOUT_CYC when alt_sel = 0.
- R4: Each fault pulse keeps fault_pulse_n low for exactly PULSE_CYC clock cycles.
- R5: fault_n falls one clock edge after fault_pulse_n falls. The two outputs never change on the same edge.
- R6: Once low, fault_n stays low until the kick line changes. It returns high at the third rising edge after that change.
- R7: On an expiry, the count restarts from zero, so another expiry follows N cycles later if there are no kicks. An expiry that finds fault_n high leaves shutdown_n high.
- R8: An expiry that finds fault_n low clears shutdown_n on the same edge that fault_pulse_n falls. reset_req = 1 whenever shutdown_n = 0.
- R9: Once shutdown_n is low, it stays low regardless of kick activity or further expiries until reactivate = 1 at a clock edge. That edge sets shutdown_n high, and reactivate takes priority over an expiry on the same edge.
- R10: A kick change between two expiries returns fault_n high, so the next expiry does not latch shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Watchdog kick; any change restarts the timeout |
| alt_sel | input | 1 | 1 selects the alternative timeout |
| reactivate | input | 1 | Clears the shutdown latch |
| fault_n | output | 1 | Active-low fault level |
| fault_pulse_n | output | 1 | Active-low fault pulse, leads fault_n |
| shutdown_n | output | 1 | Shutdown latch output, low when latched |
| reset_req | output | 1 | Persistent system reset request |

## Verification
The assertions take three things for granted about the inputs:
- PULSE_CYC is shorter than either timeout, so one pulse ends before the next expiry can start.
- kick changes no faster than once every few clocks, so the synchronizer sees every change.
- alt_sel does not switch in the middle of a count being measured.

The bench sets pulse and timeout lengths short and far apart. It changes inputs only at falling clock edges, spaces kick changes at least two cycles apart, and changes alt_sel only after a reset.

// File: rtl/wdog_two_strike.sv
module wdog_two_strike #(
  parameter int TIMEOUT_CYC     = 320_000_000,
  parameter int ALT_TIMEOUT_CYC = 4_200_000,
  parameter int PULSE_CYC       = 200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic alt_sel,
  input  logic reactivate,
  output logic fault_n,
  output logic fault_pulse_n,
  output logic shutdown_n,
  output logic reset_req
);
  localparam int MAXT = (TIMEOUT_CYC > ALT_TIMEOUT_CYC) ? TIMEOUT_CYC : ALT_TIMEOUT_CYC;
  localparam int CW   = $clog2(MAXT + 1);
  localparam int PW   = $clog2(PULSE_CYC + 1);

  logic [2:0]    ksync;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pulse_left;
  logic          expire_d;
  logic          q;

  wire           kick_edge = ksync[2] ^ ksync[1];
  wire [CW-1:0]  limit     = alt_sel ? CW'(ALT_TIMEOUT_CYC - 1) : CW'(TIMEOUT_CYC - 1);
  wire           expire    = !kick_edge && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) ksync <= '0;
    else        ksync <= {ksync[1:0], kick};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (kick_edge || expire) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               pulse_left <= '0;
    else if (expire)          pulse_left <= PW'(PULSE_CYC);
    else if (pulse_left != 0) pulse_left <= pulse_left - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expire_d <= 1'b0;
      fault_n  <= 1'b1;
    end else begin
      expire_d <= expire;
      if (kick_edge)     fault_n <= 1'b1;
      else if (expire_d) fault_n <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          q <= 1'b1;
    else if (reactivate) q <= 1'b1;
    else if (expire)     q <= q & fault_n;
  end

  assign fault_pulse_n = (pulse_left == 0);
  assign shutdown_n    = q;
  assign reset_req     = ~q;
endmodule

module wdog_two_strike_chk #(
  parameter int PULSE_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic reactivate,
  input logic fault_n,
  input logic fault_pulse_n,
  input logic shutdown_n,
  input logic reset_req
);
  localparam int LW = $clog2(PULSE_CYC + 2);
  logic [LW-1:0] lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             lowcnt <= '0;
    else if (fault_pulse_n) lowcnt <= '0;
    else                    lowcnt <= lowcnt + 1'b1;
  end

  assert_reset_vals_R1: assert property (@(posedge clk)
    !rst_n |=> (fault_n && fault_pulse_n && shutdown_n && !reset_req));

  assert_pulse_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_pulse_n |-> (lowcnt < LW'(PULSE_CYC)));

  assert_pulse_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_pulse_n) |-> ($past(lowcnt) == LW'(PULSE_CYC - 1)));

  assert_level_lags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $past($fell(fault_pulse_n)));

  assert_no_same_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_pulse_n) |-> $stable(fault_n));

  assert_second_strike_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutdown_n) |-> ($fell(fault_pulse_n) && $past(!fault_n)));

  assert_req_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> !shutdown_n);

  assert_latch_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown_n && !reactivate) |=> !shutdown_n);

  assert_reactivate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reactivate |=> shutdown_n);
endmodule

bind wdog_two_strike wdog_two_strike_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reactivate(reactivate), .fault_n(fault_n),
  .fault_pulse_n(fault_pulse_n), .shutdown_n(shutdown_n), .reset_req(reset_req)
);

// File: tb/tb_wdog_two_strike.sv
`timescale 1ns/1ps
module tb_wdog_two_strike;
  localparam int TO  = 20;
  localparam int ATO = 10;
  localparam int PL  = 3;

  logic clk = 1'b0;
  logic rst_n, kick, alt_sel, reactivate;
  logic fault_n, fault_pulse_n, shutdown_n, reset_req;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_two_strike #(.TIMEOUT_CYC(TO), .ALT_TIMEOUT_CYC(ATO), .PULSE_CYC(PL)) dut (
    .clk(clk), .rst_n(rst_n), .kick(kick), .alt_sel(alt_sel), .reactivate(reactivate),
    .fault_n(fault_n), .fault_pulse_n(fault_pulse_n), .shutdown_n(shutdown_n),
    .reset_req(reset_req)
  );

  // {toggle kick, edges to wait, expected fault_n, fault_pulse_n, reset_req}
  localparam int NV = 13;
  localparam logic [11:0] VEC [0:NV-1] = '{
    {1'b1, 8'd5,  1'b1, 1'b1, 1'b0},
    {1'b0, 8'd17, 1'b1, 1'b1, 1'b0},
    {1'b0, 8'd1,  1'b1, 1'b0, 1'b0},
    {1'b0, 8'd1,  1'b0, 1'b0, 1'b0},
    {1'b0, 8'd2,  1'b0, 1'b1, 1'b0},
    {1'b1, 8'd2,  1'b0, 1'b1, 1'b0},
    {1'b0, 8'd1,  1'b1, 1'b1, 1'b0},
    {1'b0, 8'd20, 1'b1, 1'b0, 1'b0},
    {1'b0, 8'd1,  1'b0, 1'b0, 1'b0},
    {1'b0, 8'd18, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'd1,  1'b0, 1'b0, 1'b1},
    {1'b1, 8'd3,  1'b1, 1'b1, 1'b1},
    {1'b0, 8'd30, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; kick = 1'b0; alt_sel = 1'b0; reactivate = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "fault_n in reset", fault_n, 1'b1);
    check("R1", "fault_pulse_n in reset", fault_pulse_n, 1'b1);
    check("R1", "shutdown_n in reset", shutdown_n, 1'b1);
    check("R1", "reset_req in reset", reset_req, 1'b0);
    rst_n = 1'b1;

    // table: R2 R4 R5 R6 R7 R8 R9 R10 with the normal timeout
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][11]) kick = ~kick;
      wait_edges(int'(VEC[i][10:3]));
      check("R2/R4/R5/R6/R7", $sformatf("vec %0d fault_n", i), fault_n, VEC[i][2]);
      check("R2/R4/R5/R6/R7", $sformatf("vec %0d fault_pulse_n", i), fault_pulse_n, VEC[i][1]);
      check("R8/R9/R10", $sformatf("vec %0d reset_req", i), reset_req, VEC[i][0]);
    end
    check("R8", "shutdown_n latched", shutdown_n, 1'b0);

    // R9: reactivate clears the latch
    reactivate = 1'b1;
    wait_edges(1);
    reactivate = 1'b0;
    check("R9", "reset_req after reactivate", reset_req, 1'b0);
    check("R9", "shutdown_n after reactivate", shutdown_n, 1'b1);

    // R3: alternative timeout after a fresh reset
    kick = 1'b0;
    rst_n = 1'b0;
    wait_edges(2);
    check("R1", "reset_req cleared by reset", reset_req, 1'b0);
    rst_n = 1'b1;
    alt_sel = 1'b1;
    kick = 1'b1;
    wait_edges(ATO + 2);
    check("R3", "alt pulse not yet", fault_pulse_n, 1'b1);
    wait_edges(1);
    check("R3", "alt pulse low", fault_pulse_n, 1'b0);
    check("R5", "alt level still high", fault_n, 1'b1);
    wait_edges(1);
    check("R5", "alt level low", fault_n, 1'b0);

    // R2: a kick before expiry restarts the count
    kick = 1'b0;
    wait_edges(ATO);
    kick = 1'b1;
    wait_edges(ATO + 2);
    check("R2", "restarted count no pulse", fault_pulse_n, 1'b1);
    check("R2", "no latch from restarted count", reset_req, 1'b0);
    wait_edges(1);
    check("R2", "pulse after restart", fault_pulse_n, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule